// File: doc/BRIEF.md
# Coprocessor Load Handshake Responder

This block sits on the coprocessor side of a processor-to-coprocessor link. It answers an instruction that moves words from memory into coprocessor registers. While the processor holds its instruction-valid strobe, the responder reports on two handshake lines, A and B, whether it is busy or ready to commit. Once it commits, it takes one data word per clock into a small register bank. On the final word it raises both lines, which tells the processor that the transfer has ended. The processor does not set the number of words. The responder latches it from a length input at the moment it commits.

A readiness input stands for the coprocessor's internal busy conditions. While that input is low, the responder busy-waits. If the processor withdraws its strobe during the busy-wait, for example to take an interrupt, the responder drops the request. It writes nothing and returns to idle. A combinational read port lets the surrounding logic inspect the register bank.

The controller has four states:
- **IDLE** drives A/B = 1/1.
- **BUSY** drives 0/1.
- **COMMIT** drives 0/0.
- **XFER** drives 0/0 on each word except the last, and 1/1 on the last word.

The transitions are:
- **IDLE→BUSY**: the strobe is seen.
- **BUSY→IDLE**: abandon.
- **BUSY→BUSY**: wait.
- **BUSY→COMMIT**: ready with the strobe held.
- **COMMIT→XFER**: always.
- **XFER→XFER**: another word follows.
- **XFER→IDLE**: the last word.

Top module: `cp_load_responder`

## Requirements
- R1: After reset, and whenever no instruction is in progress, A/B read 1/1, and every bank register reads zero after reset.
- R2: If the strobe is high at a clock edge while the block is idle, A/B read 0/1 from the next cycle. They stay 0/1 as long as the readiness input is low and the strobe stays high.
- R3: While busy, if the strobe and readiness are both high at a clock edge, A/B read 0/0 for exactly one commit cycle.
- R4: Data cycles begin on the clock after the commit cycle. There are exactly L = len_m1+1 consecutive data cycles. A/B read 0/0 on the first L-1 of them and 1/1 on the last.
- R5: In data cycle k (counting from 0), the word on bus_data is written into bank register k at the closing clock edge. One word is taken per clock, with no stall.
- R6: len_m1 is sampled at the edge that moves the block from busy to commit. Changes to len_m1 after that edge do not affect the current transfer.
- R7: If the strobe is low at a clock edge while busy, A/B return to 1/1 on the next cycle and no bank register is written. This holds even when readiness is high at that same edge: abandon takes precedence over commit.
- R8: The strobe is ignored during the commit and data cycles. A transfer that has been committed always runs to its last word.
- R9: After the last data cycle, A/B read 1/1. A strobe that is high at that last edge is treated as a fresh request, and A/B read 0/1 one cycle later.
- R10: rd_data always shows the bank register selected by rd_idx. Registers outside the words just transferred keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_vld | input | 1 | Processor's strobe marking the load instruction as valid |
| cp_ready | input | 1 | High when the coprocessor can accept the transfer |
| len_m1 | input | IDXW | Transfer length minus one (0 means 1 word, 15 means 16 words) |
| bus_data | input | DW | Incoming data word |
| rd_idx | input | IDXW | Bank register to show on rd_data |
| hs_a | output | 1 | Handshake line A |
| hs_b | output | 1 | Handshake line B |
| rd_data | output | DW | Contents of the selected bank register |

## Verification
Two functions can meet in one busy cycle: the processor abandoning the instruction, and the coprocessor becoming ready. The bench provokes this by dropping the strobe at the same edge at which it raises readiness, after both zero and several busy-wait cycles. The behavioural model expects abandon to win. That means 1/1 on the following cycle, and a bank readback equal to the bank's contents before the attempt. A second overlap occurs at a last data word: the end of one transfer and the start of the next request fall on the same edge. The bench judges this by checking that 0/1 appears directly after the final 1/1.

// File: rtl/cp_load_pkg.sv
package cp_load_pkg;

    typedef enum logic [1:0] {
        CPL_IDLE   = 2'd0,
        CPL_BUSY   = 2'd1,
        CPL_COMMIT = 2'd2,
        CPL_XFER   = 2'd3
    } cpl_state_e;

endpackage

// File: rtl/cp_load_fsm.sv
module cp_load_fsm
    import cp_load_pkg::*;
#(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_vld,
    input  logic            cp_ready,
    input  logic [IDXW-1:0] len_m1,
    output cpl_state_e      st,
    output logic [IDXW-1:0] wr_idx,
    output logic            wr_en,
    output logic            hs_a,
    output logic            hs_b
);

    cpl_state_e      nxt;
    logic [IDXW-1:0] len_q;
    logic [IDXW-1:0] idx_q;
    logic            last_word;

    assign last_word = (idx_q == len_q);

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            CPL_IDLE:   if (instr_vld) nxt = CPL_BUSY;
            CPL_BUSY: begin
                if (!instr_vld)    nxt = CPL_IDLE;    // abandon wins
                else if (cp_ready) nxt = CPL_COMMIT;
            end
            CPL_COMMIT: nxt = CPL_XFER;
            CPL_XFER:   if (last_word) nxt = CPL_IDLE;
        endcase
    end

    // state register, length latch and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= CPL_IDLE;
            len_q <= '0;
            idx_q <= '0;
        end else begin
            st <= nxt;
            if (st == CPL_BUSY && nxt == CPL_COMMIT)
                len_q <= len_m1;
            if (st == CPL_COMMIT)
                idx_q <= '0;
            else if (st == CPL_XFER && !last_word)
                idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        hs_a  = 1'b1;
        hs_b  = 1'b1;
        wr_en = 1'b0;
        unique case (st)
            CPL_IDLE:   begin hs_a = 1'b1; hs_b = 1'b1; end
            CPL_BUSY:   begin hs_a = 1'b0; hs_b = 1'b1; end
            CPL_COMMIT: begin hs_a = 1'b0; hs_b = 1'b0; end
            CPL_XFER: begin
                hs_a  = last_word;
                hs_b  = last_word;
                wr_en = 1'b1;
            end
        endcase
    end

    assign wr_idx = idx_q;

endmodule

// File: rtl/cp_load_bank.sv
module cp_load_bank #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IDXW'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/cp_load_responder.sv
module cp_load_responder
    import cp_load_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_vld,
    input  logic            cp_ready,
    input  logic [IDXW-1:0] len_m1,
    input  logic [DW-1:0]   bus_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic            hs_a,
    output logic            hs_b,
    output logic [DW-1:0]   rd_data
);

    cpl_state_e      st;
    logic [IDXW-1:0] wr_idx;
    logic            wr_en;

    cp_load_fsm #(.IDXW(IDXW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_vld (instr_vld),
        .cp_ready  (cp_ready),
        .len_m1    (len_m1),
        .st        (st),
        .wr_idx    (wr_idx),
        .wr_en     (wr_en),
        .hs_a      (hs_a),
        .hs_b      (hs_b)
    );

    cp_load_bank #(.DW(DW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (bus_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cp_load_responder_chk.sv
module cp_load_responder_chk
    import cp_load_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       instr_vld,
    input logic       cp_ready,
    input logic       hs_a,
    input logic       hs_b,
    input cpl_state_e st,
    input logic       wr_en
);

    a_r2_enter_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CPL_IDLE && instr_vld) |=> (!hs_a && hs_b));

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_a && hs_b && instr_vld && cp_ready) |=> (!hs_a && !hs_b));

    a_r4_commit_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CPL_COMMIT) |=> (st == CPL_XFER));

    a_r4_no_half_line: assert property (@(posedge clk) disable iff (!rst_n)
        hs_a |-> hs_b);

    a_r5_write_in_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st == CPL_XFER));

    a_r7_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_a && hs_b && !instr_vld) |=> (hs_a && hs_b && !wr_en));

    a_r9_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CPL_XFER && hs_a) |=> (st != CPL_XFER));

endmodule

bind cp_load_responder cp_load_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_vld (instr_vld),
    .cp_ready  (cp_ready),
    .hs_a      (hs_a),
    .hs_b      (hs_b),
    .st        (st),
    .wr_en     (wr_en)
);

// File: tb/test_cp_load_responder.sv
module test_cp_load_responder;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 32;
    localparam int NREG = 16;
    localparam int IDXW = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            instr_vld = 1'b0;
    logic            cp_ready = 1'b0;
    logic [IDXW-1:0] len_m1 = '0;
    logic [DW-1:0]   bus_data = '0;
    logic [IDXW-1:0] rd_idx = '0;
    logic            hs_a, hs_b;
    logic [DW-1:0]   rd_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // behavioural reference model: 0 idle, 1 busy, 2 commit, 3 data
    int            mst = 0;
    int            mcnt = 0;
    int            mlen = 0;
    logic [DW-1:0] mbank [NREG];

    cp_load_responder #(.DW(DW), .NREG(NREG)) i_cp_load_responder (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .cp_ready(cp_ready),
        .len_m1(len_m1), .bus_data(bus_data), .rd_idx(rd_idx),
        .hs_a(hs_a), .hs_b(hs_b), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mcnt = 0; mlen = 0;
            for (int i = 0; i < NREG; i++) mbank[i] = '0;
        end else begin
            case (mst)
                0: if (instr_vld) mst = 1;
                1: if (!instr_vld) mst = 0;
                   else if (cp_ready) begin mlen = int'(len_m1); mst = 2; end
                2: begin mcnt = 0; mst = 3; end
                default: begin
                    mbank[mcnt] = bus_data;
                    if (mcnt == mlen) mst = 0; else mcnt++;
                end
            endcase
        end
    end

    // per-cycle handshake comparison
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] exp_hs;
            string tag;
            case (mst)
                0: begin exp_hs = 2'b11; tag = "R1/R9"; end
                1: begin exp_hs = 2'b01; tag = "R2"; end
                2: begin exp_hs = 2'b00; tag = "R3"; end
                default: begin
                    exp_hs = (mcnt == mlen) ? 2'b11 : 2'b00;
                    tag = "R4";
                end
            endcase
            checks++;
            if ({hs_a, hs_b} !== exp_hs) begin
                errors++;
                $display("FAIL %s cycle %0d: hs=%b expected %b", tag, cyc, {hs_a, hs_b}, exp_hs);
            end
        end
    end

    task automatic step(input logic v, input logic r, input int l);
        @(negedge clk);
        instr_vld = v;
        cp_ready  = r;
        len_m1    = IDXW'(l);
        cyc++;
        bus_data  = 32'hC0DE_0000 + DW'(cyc * 7);
    endtask

    task automatic readback(input string tag);
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk);
            rd_idx = IDXW'(i);
            #1;
            checks++;
            if (rd_data !== mbank[i]) begin
                errors++;
                $display("FAIL %s reg %0d: got %h expected %h", tag, i, rd_data, mbank[i]);
            end
        end
    endtask

    // R4 R5 R6 R8 R9: full transfer with optional busy wait
    task automatic run_xfer(input int nbusy, input int len, input bit drop_vld, input bit chain);
        step(1, 0, len);
        for (int i = 0; i < nbusy; i++) step(1, 0, len);
        step(1, 1, len);
        for (int g = 0; g < 40; g++) begin
            // R6: length input scrambled after commit; R8: strobe dropped
            step(drop_vld ? 1'b0 : 1'b1, 1'b0, (len + 5) % NREG);
            if (mst == 3 && mcnt == mlen) break;
        end
        if (chain) step(1, 0, len);   // R9: new request on last edge
        else       step(0, 0, len);
    endtask

    // R7: abandon while busy, optionally with ready at the same edge
    task automatic abandon(input int nbusy, input bit rdy_same);
        step(1, 0, 3);
        for (int i = 0; i < nbusy; i++) step(1, 0, 3);
        step(0, rdy_same, 3);
        step(0, 0, 3);
        step(0, 0, 3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of handshake and bank
        #1;
        checks++;
        if ({hs_a, hs_b} !== 2'b11) begin
            errors++;
            $display("FAIL R1 reset hs=%b expected 11", {hs_a, hs_b});
        end
        readback("R1");
        step(0, 1, 0);                    // ready alone does nothing
        run_xfer(0, 0, 0, 0);             // single word, no wait
        readback("R5");
        run_xfer(3, 3, 0, 0);             // four words after busy wait
        readback("R5");
        run_xfer(1, 15, 1, 0);            // sixteen words, strobe dropped (R8)
        readback("R8");
        run_xfer(0, 2, 0, 1);             // chained start (R9)
        run_xfer(2, 5, 0, 0);
        readback("R10");
        abandon(2, 0);                    // R7 plain abandon
        readback("R7");
        abandon(0, 1);                    // R7 abandon beats ready
        abandon(4, 1);
        readback("R7");
        run_xfer(0, 1, 0, 0);             // R6 scrambled length input
        readback("R6");
        repeat (3) step(0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule